// File: doc/BRIEF.md
# Display command serial master with separate data/command line

This block is a serial master for small display controllers. Such controllers take a command byte followed by parameter bytes, and they tell the two apart with a dedicated data/command line rather than a ninth bit. A request carries one command byte and a length. For a write, the length is the number of parameter bytes, which the block pulls one at a time from a source that always presents its next byte. For a read, the length is the number of bytes to return, and they come out one per pulse on a valid strobe.

The serial side runs in mode 0, MSB first. Chip select stays low for the whole transaction. The clock rate is chosen per phase from three half-period counts, each derived from the system clock and a target frequency:

- a maximum rate;
- a limited rate, used for command bytes and short parameter runs;
- a read rate, the lower of the read limit and half the maximum.

Two status-style read commands are answered by the controller with one dummy clock first. For these commands the block clocks one extra byte and shifts the returned stream left by one bit. A read of length zero is refused with a one-cycle error pulse, and so is a read of these two commands with a length other than 3 or 4.

Top module: `lcd_cmd_spi`

## Requirements
- R1: The command byte is shifted first, MSB first, with `dc` low for all of its eight bits.
- R2: On a write, exactly `len` parameter bytes follow the command byte, in order, with `dc` high. The block pulses `wr_take` once for each byte and samples `wr_data` at that edge. When `len` is 0 the transaction ends after the command byte. Every accepted transaction ends with a one-cycle `done` pulse.
- R3: `sclk` idles low. `mosi` changes only while `sclk` is low, so each bit is stable across its rising edge. `dc` is constant across each byte.
- R4: Chip select goes low one half-period before the first rising edge and goes high one half-period after the last falling edge. With command half-period hc, data half-period hd and N data bytes, `cs_n` is low for exactly 16*hc + 16*N*hd + h cycles, where h = hd if N > 0 and h = hc otherwise.
- R5: A half-period is ceil(SYS_HZ / (2*f)) system cycles. For a write, the command byte and parameter runs of SHORT_MAX (64) bytes or fewer run at f = min(LIMIT_SCK_HZ, MAX_SCK_HZ). Longer parameter runs run at f = MAX_SCK_HZ.
- R6: A read sends the command byte with `dc` low. It then clocks N data bytes without releasing chip select, with `mosi` low and `dc` low. The whole read runs at f = min(READ_SCK_HZ, MAX_SCK_HZ/2).
- R7: `rd_valid` pulses once for each returned byte, in order, with the byte on `rd_data`. It never pulses during a write.
- R8: For a read of command 0x04 or 0x09, N = `len` + 1. Returned byte i is {raw[i][6:0], raw[i+1][7]}, where raw[k] is the k-th data byte sampled from `miso`. For all other reads N = `len` and returned byte i is raw[i].
- R9: A read with `len` 0 produces a one-cycle `err` pulse. It causes no chip-select activity and no `done` pulse.
- R10: A read of command 0x04 or 0x09 with `len` other than 3 or 4 is refused in the same way as R9.
- R11: A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only when idle |
| is_read | input | 1 | 1 = read transaction, 0 = write |
| cmd | input | 8 | Command byte |
| len | input | LEN_W | Parameter count (write) or return count (read) |
| wr_data | input | 8 | Next parameter byte, valid whenever it is requested |
| wr_take | output | 1 | Parameter byte consumed at this edge |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| err | output | 1 | One-cycle pulse for a refused read |
| rd_data | output | 8 | Returned read byte |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |
| dc | output | 1 | Data/command select, low = command |

## Verification
Writes are tried with lengths 0, 1, 4, 64, 65 and 100. This separates a command-only frame from short runs, and puts runs on either side of the 64-byte rate threshold. Chip-select low time is measured in cycles and compared with the formula, so a wrong rate choice shows up as a count mismatch.

Reads of a plain command with lengths 1 and 2 separate straight return from the realigned mode. Reads of the two dummy-clock commands with lengths 3 and 4 check the one-bit shift against a slave that drives a known byte pattern. Refused reads (length 0, and lengths 2 and 5 on the dummy-clock commands) and a second `start` issued mid-transfer check that nothing reaches the serial lines.

// File: rtl/lcd_cmd_spi_pkg.sv
package lcd_cmd_spi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HI,
        ST_LO,
        ST_TRAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_WR,
        PH_RD
    } phase_t;

    localparam logic [7:0] CMD_READ_ID     = 8'h04;
    localparam logic [7:0] CMD_READ_STATUS = 8'h09;

    // Half-period in system cycles, rounded up so the rate never exceeds f.
    function automatic int unsigned half_cycles(input int unsigned sys_hz,
                                                input int unsigned f_hz);
        longint unsigned num;
        longint unsigned den;
        num = longint'(sys_hz) + 2 * longint'(f_hz) - 1;
        den = 2 * longint'(f_hz);
        return int'(num / den);
    endfunction

    function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Commands whose response is preceded by one dummy clock.
    function automatic logic has_dummy_clock(input logic [7:0] c);
        return (c == CMD_READ_ID) || (c == CMD_READ_STATUS);
    endfunction

endpackage

// File: rtl/lcd_cmd_check.sv
module lcd_cmd_check
    import lcd_cmd_spi_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             is_read,
    input  logic [7:0]       cmd,
    input  logic [LEN_W-1:0] len,
    output logic             reject,
    output logic             extra
);
    logic dummy;
    logic len_ok;

    always_comb begin
        dummy  = is_read && has_dummy_clock(cmd);
        len_ok = (len == LEN_W'(3)) || (len == LEN_W'(4));
        extra  = dummy;
        // R9: zero-length read; R10: bad length on dummy-clock command
        reject = is_read && ((len == '0) || (dummy && !len_ok));
    end
endmodule

// File: rtl/lcd_rx_align.sv
module lcd_rx_align (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       extra,
    input  logic       stb,
    input  logic [7:0] raw,
    output logic [7:0] rd_data,
    output logic       rd_valid
);
    logic [7:0] prev;
    logic       first;
    logic       ex_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev     <= '0;
            first    <= 1'b1;
            ex_q     <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (clear) begin
                first <= 1'b1;
                ex_q  <= extra;
            end else if (stb) begin
                prev <= raw;
                if (!ex_q) begin
                    rd_data  <= raw;
                    rd_valid <= 1'b1;
                end else if (first) begin
                    first <= 1'b0;
                end else begin
                    rd_data  <= {prev[6:0], raw[7]};
                    rd_valid <= 1'b1;
                end
            end
        end
    end

    // R8: the first raw byte of a realigned read produces no output
    assert_realign_skip_R8: assert property (@(posedge clk) disable iff (rst)
        (stb && !clear && ex_q && first) |=> !rd_valid);
endmodule

// File: rtl/lcd_cmd_spi.sv
module lcd_cmd_spi
    import lcd_cmd_spi_pkg::*;
#(
    parameter int unsigned SYS_HZ       = 100_000_000,
    parameter int unsigned MAX_SCK_HZ   = 25_000_000,
    parameter int unsigned LIMIT_SCK_HZ = 10_000_000,
    parameter int unsigned READ_SCK_HZ  = 2_000_000,
    parameter int unsigned SHORT_MAX    = 64,
    parameter int          LEN_W        = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             is_read,
    input  logic [7:0]       cmd,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n,
    output logic             dc
);
    localparam int unsigned FAST_H = half_cycles(SYS_HZ, MAX_SCK_HZ);
    localparam int unsigned LIM_H  = half_cycles(SYS_HZ, min_u(LIMIT_SCK_HZ, MAX_SCK_HZ));
    localparam int unsigned RD_H   = half_cycles(SYS_HZ, min_u(READ_SCK_HZ, MAX_SCK_HZ / 2));
    localparam int unsigned MAX_H  = max_u(FAST_H, max_u(LIM_H, RD_H));
    localparam int          TMR_W  = $clog2(MAX_H + 1);
    localparam logic [TMR_W-1:0] FAST_R = TMR_W'(FAST_H - 1);
    localparam logic [TMR_W-1:0] LIM_R  = TMR_W'(LIM_H - 1);
    localparam logic [TMR_W-1:0] RD_R   = TMR_W'(RD_H - 1);

    seq_state_t       state;
    phase_t           phase;
    logic [TMR_W-1:0] tmr;
    logic [TMR_W-1:0] cur_r;
    logic [TMR_W-1:0] data_r;
    logic [2:0]       bit_cnt;
    logic [LEN_W:0]   left;
    logic [7:0]       tx_sh;
    logic [7:0]       rx_sh;
    logic             sclk_q, cs_q, dc_q, rd_q, done_q, err_q;

    logic reject, extra, accept, byte_end, rx_stb;

    lcd_cmd_check #(.LEN_W(LEN_W)) u_check (
        .is_read (is_read),
        .cmd     (cmd),
        .len     (len),
        .reject  (reject),
        .extra   (extra)
    );

    assign accept   = (state == ST_IDLE) && start && !reject;
    assign byte_end = (state == ST_HI) && (tmr == '0) && (bit_cnt == 3'd0);
    assign rx_stb   = byte_end && (phase == PH_RD);
    assign wr_take  = byte_end && (left != '0) && !rd_q;

    lcd_rx_align u_align (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .extra    (extra),
        .stb      (rx_stb),
        .raw      (rx_sh),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            phase   <= PH_CMD;
            tmr     <= '0;
            cur_r   <= '0;
            data_r  <= '0;
            bit_cnt <= '0;
            left    <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            sclk_q  <= 1'b0;
            cs_q    <= 1'b1;
            dc_q    <= 1'b0;
            rd_q    <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start && reject) begin
                        err_q <= 1'b1;
                    end else if (start) begin
                        cs_q    <= 1'b0;
                        dc_q    <= 1'b0;
                        tx_sh   <= cmd;
                        bit_cnt <= 3'd7;
                        phase   <= PH_CMD;
                        rd_q    <= is_read;
                        left    <= (LEN_W+1)'(len) + (LEN_W+1)'(extra);
                        data_r  <= is_read ? RD_R
                                 : ((32'(len) > SHORT_MAX) ? FAST_R : LIM_R);
                        cur_r   <= is_read ? RD_R : LIM_R;
                        tmr     <= is_read ? RD_R : LIM_R;
                        state   <= ST_LEAD;
                    end
                end
                ST_LEAD, ST_LO: begin
                    if (tmr == '0) begin
                        sclk_q <= 1'b1;
                        rx_sh  <= {rx_sh[6:0], miso};
                        tmr    <= cur_r;
                        state  <= ST_HI;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_HI: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else begin
                        sclk_q <= 1'b0;
                        if (bit_cnt != 3'd0) begin
                            bit_cnt <= bit_cnt - 3'd1;
                            tx_sh   <= {tx_sh[6:0], 1'b0};
                            tmr     <= cur_r;
                            state   <= ST_LO;
                        end else if (left != '0) begin
                            left    <= left - 1'b1;
                            bit_cnt <= 3'd7;
                            tx_sh   <= rd_q ? 8'h00 : wr_data;
                            dc_q    <= !rd_q;
                            phase   <= rd_q ? PH_RD : PH_WR;
                            cur_r   <= data_r;
                            tmr     <= data_r;
                            state   <= ST_LO;
                        end else begin
                            tmr   <= cur_r;
                            state <= ST_TRAIL;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tmr == '0) begin
                        cs_q   <= 1'b1;
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
    assign done = done_q;
    assign err  = err_q;
    assign sclk = sclk_q;
    assign mosi = tx_sh[7];
    assign cs_n = cs_q;
    assign dc   = dc_q;

    assert_cmd_dc_low_R1: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && phase == PH_CMD) |-> !dc);

    assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    assert_idle_lines_R4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cs_n && !sclk));

    assert_reject_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        err |-> (cs_n && !busy));

    assert_rdvalid_read_R7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rd_q);

    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (rd_q == $past(rd_q)));
endmodule

// File: tb/lcd_cmd_spi_test.sv
module lcd_cmd_spi_test;
    localparam int LW   = 12;
    localparam int SYS  = 100_000_000;
    localparam int MAXF = 25_000_000;
    localparam int LIMF = 10_000_000;
    localparam int RDF  = 2_000_000;
    localparam int FH = (SYS + 2*MAXF - 1) / (2*MAXF);
    localparam int LH = (SYS + 2*LIMF - 1) / (2*LIMF);
    localparam int RH = (SYS + 2*RDF - 1) / (2*RDF);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, start, is_read;
    logic [7:0] cmd;
    logic [LW-1:0] len;
    logic [7:0] wr_data;
    logic wr_take, busy, done, err, rd_valid, sclk, mosi, miso, cs_n, dc;
    logic [7:0] rd_data;

    lcd_cmd_spi #(.LEN_W(LW)) uut (
        .clk(clk), .rst(rst), .start(start), .is_read(is_read), .cmd(cmd),
        .len(len), .wr_data(wr_data), .wr_take(wr_take), .busy(busy),
        .done(done), .err(err), .rd_data(rd_data), .rd_valid(rd_valid),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .dc(dc)
    );

    int checks = 0;
    int failures = 0;
    logic [7:0] cur_cmd = 8'h00;

    function automatic logic [7:0] wpat(input int k);
        return 8'((k * 29 + 7) ^ int'(cur_cmd));
    endfunction

    function automatic logic [7:0] spat(input int k);
        return 8'(k * 53 + 8'hA5 + int'(cur_cmd));
    endfunction

    // monitor state
    int ncap, nbit, nrd, cs_cycles, done_cnt, err_cnt, take_cnt, mbit;
    bit take_prev, sclk_prev, mixed, dcb;
    logic [7:0] shv;
    logic [7:0] cap [0:127];
    bit         cap_dc [0:127];
    logic [7:0] rdcap [0:15];

    function automatic logic miso_bit(input int m, input logic csn);
        int b;
        logic [7:0] s;
        if (csn || m < 8) return 1'b0;
        b = m - 8;
        s = spat(b / 8);
        return s[7 - (b % 8)];
    endfunction

    assign wr_data = wpat(take_cnt);
    assign miso    = miso_bit(mbit, cs_n);

    always @(negedge clk) begin
        if (start && !busy) begin
            ncap = 0; nbit = 0; nrd = 0; cs_cycles = 0; done_cnt = 0;
            err_cnt = 0; take_cnt = 0; mixed = 0; take_prev = 0; shv = 0;
        end else begin
            if (!cs_n) cs_cycles++;
            if (cs_n) mbit = 0;
            if (sclk && !sclk_prev) begin
                shv = {shv[6:0], mosi};
                if (nbit == 0) dcb = dc;
                else if (dc != dcb) mixed = 1;
                nbit++;
                mbit++;
                if (nbit == 8) begin
                    if (ncap < 128) begin
                        cap[ncap] = shv;
                        cap_dc[ncap] = dcb;
                    end
                    ncap++;
                    nbit = 0;
                end
            end
            if (take_prev) take_cnt++;
            take_prev = wr_take;
            if (rd_valid) begin
                if (nrd < 16) rdcap[nrd] = rd_data;
                nrd++;
            end
            if (done) done_cnt++;
            if (err) err_cnt++;
        end
        sclk_prev = sclk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input logic rd, input logic [7:0] c, input int n, input bit poke);
        int to;
        cur_cmd = c;
        is_read = rd;
        cmd = c;
        len = LW'(n);
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        to = 0;
        while (done_cnt == 0 && err_cnt == 0 && to < 30000) begin
            @(negedge clk); #1;
            to++;
            if (poke && to == 40) begin
                is_read = 1'b1; cmd = 8'h00; len = '0; start = 1'b1;
                @(posedge clk); #2 start = 1'b0;
            end
        end
        chk(to < 30000, "R2 completion", to, 0);
        repeat (4) @(negedge clk);
        #1;
    endtask

    task automatic do_write(input logic [7:0] c, input int n, input bit poke);
        int bad, hd, exp;
        run(1'b0, c, n, poke);
        chk(done_cnt == 1, "R2 done pulse", done_cnt, 1);
        chk(ncap == n + 1, "R2 byte count", ncap, n + 1);
        chk(cap[0] == c && cap_dc[0] == 1'b0, "R1 command byte dc low", int'(cap[0]), int'(c));
        bad = 0;
        for (int k = 0; k < n; k++)
            if (cap[k+1] != wpat(k) || !cap_dc[k+1]) bad++;
        chk(bad == 0, "R2 parameter bytes with dc high", bad, 0);
        chk(take_cnt == n, "R2 take pulses", take_cnt, n);
        chk(mixed == 0, "R3 dc constant per byte", int'(mixed), 0);
        chk(nrd == 0, "R7 no rd_valid on write", nrd, 0);
        hd = (n > 64) ? FH : LH;
        exp = 16*LH + 16*n*hd + ((n > 0) ? hd : LH);
        chk(cs_cycles == exp, n > 64 ? "R5 fast rate frame length" : "R4 frame length", cs_cycles, exp);
        if (poke) chk(err_cnt == 0, "R11 start while busy ignored", err_cnt, 0);
    endtask

    task automatic do_read(input logic [7:0] c, input int n);
        int nn, bad, exp;
        bit ex;
        logic [7:0] e;
        ex = (c == 8'h04) || (c == 8'h09);
        nn = n + (ex ? 1 : 0);
        run(1'b1, c, n, 1'b0);
        chk(done_cnt == 1 && err_cnt == 0, "R6 read completes", done_cnt, 1);
        chk(ncap == 1 + nn, "R8 clocked byte count", ncap, 1 + nn);
        chk(cap[0] == c && cap_dc[0] == 1'b0, "R1 read command byte", int'(cap[0]), int'(c));
        bad = 0;
        for (int k = 1; k <= nn; k++)
            if (cap[k] != 8'h00 || cap_dc[k]) bad++;
        chk(bad == 0, "R6 mosi and dc low on read bytes", bad, 0);
        chk(nrd == n, "R7 rd_valid count", nrd, n);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            e = ex ? {spat(i)[6:0], spat(i+1)[7]} : spat(i);
            if (rdcap[i] != e) begin
                bad++;
                $display("FAIL R8 byte %0d actual=%0d expected=%0d", i, rdcap[i], e);
            end
        end
        chk(bad == 0, ex ? "R8 realigned data" : "R7 read data", bad, 0);
        exp = RH * (17 + 16*nn);
        chk(cs_cycles == exp, "R6 read rate frame length", cs_cycles, exp);
    endtask

    task automatic do_reject(input logic [7:0] c, input int n, input string req);
        run(1'b1, c, n, 1'b0);
        chk(err_cnt == 1, req, err_cnt, 1);
        chk(cs_cycles == 0 && ncap == 0, req, cs_cycles, 0);
        chk(done_cnt == 0, req, done_cnt, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; is_read = 1'b0; cmd = 8'h00; len = '0;
        repeat (5) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk); #1;
        chk(cs_n == 1'b1 && sclk == 1'b0, "R4 reset lines idle", int'(cs_n), 1);
        chk(busy == 1'b0 && done == 1'b0 && err == 1'b0 && rd_valid == 1'b0,
            "R3 reset outputs quiet", int'(busy), 0);

        do_write(8'h2A, 4, 1'b0);
        do_write(8'h29, 0, 1'b0);
        do_write(8'h36, 1, 1'b0);
        do_write(8'h2C, 64, 1'b0);
        do_write(8'h2C, 65, 1'b0);
        do_write(8'h2C, 100, 1'b0);
        do_write(8'h2B, 8, 1'b1);

        do_read(8'h0A, 1);
        do_read(8'h0C, 2);
        do_read(8'h04, 3);
        do_read(8'h04, 4);
        do_read(8'h09, 4);
        do_read(8'h09, 3);

        do_reject(8'h0A, 0, "R9 zero-length read refused");
        do_reject(8'h04, 2, "R10 short id read refused");
        do_reject(8'h09, 5, "R10 long status read refused");

        do_write(8'h13, 2, 1'b0);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R3 lines idle after run", int'(sclk), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule